// File: doc/BRIEF.md
# Edge-Latched Event Status Register with Interrupt

This block collects four event sources into one byte of sticky status bits for a line framer's host interface. Three of the sources are live condition levels from other clock domains: counter overflow, loss of the transmit clock and loss of the receive clock. The fourth is a one-second boundary produced by an internal tick generator. The generator counts rising edges of one of two line clocks, and a control bit picks which one. A status bit is set by a new event only. For the three conditions that means a 0-to-1 transition, not the level. Once set, the bit stays set until the host clears it.

The host reads the status byte at address 09h. It clears bits by writing ones to them; a written zero leaves the bit alone. A separate enable byte holds one enable per status bit. The single active-high interrupt output is the registered OR of every status bit whose enable is also set.

A one-bit control register selects the reference clock for the one-second generator. Reads take one cycle: the data appears together with a valid strobe on the cycle after the read request.

Top module: `evt_status_reg`

## Requirements
- R1: The status byte is read at address 09h. Its layout is: bit 0 is the one-second event, bit 1 counter overflow, bit 6 loss of transmit clock, bit 7 loss of receive clock. Bits 2 to 5 always read 0. The enable byte at address 0Ah reads back only bits 0, 1, 6 and 7; its other bits read 0.
- R2: The overflow and loss-of-clock status bits are set by a 0-to-1 transition of their live input. The transition is seen within four clock cycles.
- R3: Writing a 1 to a status bit position at 09h clears that bit. Writing a 0 leaves it unchanged.
- R4: After a clear, a status bit stays 0 while its live input remains high. It sets again only on a new rising edge.
- R5: The one-second bit is set each time the selected reference clock completes its terminal count of rising edges. Control register 0Bh bit 0 selects the clock: 0 for the receive line clock, 1 for the transmit input clock. The edge count restarts when the select changes. A stopped selected clock produces no event.
- R6: irq is 1 one cycle after any status bit and its matching enable bit (same position at 0Ah) are both 1, and 0 otherwise.
- R7: Clearing either the status bit or its enable bit removes that bit's contribution to irq.
- R8: When a set event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R9: After reset, all status bits, enables and the select are 0, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| live_ovf | input | 1 | Live counter overflow condition (asynchronous) |
| live_lotc | input | 1 | Live loss-of-transmit-clock condition (asynchronous) |
| live_lorc | input | 1 | Live loss-of-receive-clock condition (asynchronous) |
| rx_line_clk | input | 1 | Receive line clock, a one-second reference |
| tx_in_clk | input | 1 | Transmit input clock, a one-second reference |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 1 | Active-high interrupt |

## Verification
A status bit that latches on the level instead of the edge shows up as a bit that reappears within four cycles of a clear while its input is still high. A clear-priority error shows as a lost bit when a clear meets a new edge. Either fault is visible on the next read of 09h. Enable or OR-reduction faults appear on irq one cycle after the enable or status change. A wrong clock select or a wrong terminal count shows as a missing or extra one-second bit within one tick period of the selected clock.

// File: rtl/evsr_pkg.sv
package evsr_pkg;
  localparam int DW        = 8;
  localparam int AW        = 8;
  localparam int BIT_SEC   = 0;
  localparam int BIT_OVF   = 1;
  localparam int BIT_LTX   = 6;
  localparam int BIT_LRX   = 7;
  localparam logic [DW-1:0] USED_MASK = (DW'(1) << BIT_SEC) | (DW'(1) << BIT_OVF)
                                      | (DW'(1) << BIT_LTX) | (DW'(1) << BIT_LRX);
  localparam logic [AW-1:0] ADDR_STAT = 8'h09;
  localparam logic [AW-1:0] ADDR_IEN  = 8'h0A;
  localparam logic [AW-1:0] ADDR_CTRL = 8'h0B;
  localparam int NLIVE     = 3;
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sec_tick.sv
module sec_tick #(
  parameter int RX_TC = 44_736_000,
  parameter int TX_TC = 34_368_000
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_ref,
  input  logic tx_ref,
  input  logic sel,
  output logic tick
);
  localparam int MAXTC = (RX_TC > TX_TC) ? RX_TC : TX_TC;
  localparam int CW    = $clog2(MAXTC + 1);

  logic [1:0]    ref_s;
  logic [1:0]    ref_prev;
  logic [1:0]    ref_rise;
  logic          sel_q;
  logic          ref_edge;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  sync2 #(.W(2)) u_ref_sync (
    .clk (clk),
    .rst (rst),
    .d   ({tx_ref, rx_ref}),
    .q   (ref_s)
  );

  assign ref_rise = ref_s & ~ref_prev;

  always_comb begin
    ref_edge = sel ? ref_rise[1] : ref_rise[0];
    lim      = sel ? CW'(TX_TC - 1) : CW'(RX_TC - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_prev <= '0;
      sel_q    <= 1'b0;
      cnt      <= '0;
      tick     <= 1'b0;
    end else begin
      ref_prev <= ref_s;
      sel_q    <= sel;
      tick     <= 1'b0;
      if (sel != sel_q) begin
        cnt <= '0;
      end else if (ref_edge) begin
        if (cnt == lim) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst) tick |=> !tick); // R5
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) (sel == sel_q) |-> (cnt <= lim)); // R5
endmodule

// File: rtl/edge_latch.sv
module edge_latch #(
  parameter bit EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic clr,
  output logic q
);
  logic set_pulse;

  generate
    if (EDGE) begin : g_edge
      logic src_prev;
      always_ff @(posedge clk) begin
        if (rst) src_prev <= 1'b0;
        else     src_prev <= src;
      end
      assign set_pulse = src & ~src_prev;
    end else begin : g_pulse
      assign set_pulse = src;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)            q <= 1'b0;
    else if (set_pulse) q <= 1'b1;
    else if (clr)       q <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) set_pulse |=> q); // R8
  AST_CLEAR: assert property (@(posedge clk) disable iff (rst) (clr && !set_pulse) |=> !q); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (rst) (!clr && !set_pulse) |=> $stable(q)); // R4
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import evsr_pkg::*;
#(
  parameter int RX_TC = 44_736_000,
  parameter int TX_TC = 34_368_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          live_ovf,
  input  logic          live_lotc,
  input  logic          live_lorc,
  input  logic          rx_line_clk,
  input  logic          tx_in_clk,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  output logic          irq
);
  logic [NLIVE-1:0] live_s;
  logic             tick;
  logic             sel;
  logic [DW-1:0]    stat;
  logic [DW-1:0]    ien;
  logic [DW-1:0]    clr_vec;
  logic             wr_stat;

  sync2 #(.W(NLIVE)) u_live_sync (
    .clk (clk),
    .rst (rst),
    .d   ({live_lorc, live_lotc, live_ovf}),
    .q   (live_s)
  );

  sec_tick #(.RX_TC(RX_TC), .TX_TC(TX_TC)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .rx_ref (rx_line_clk),
    .tx_ref (tx_in_clk),
    .sel    (sel),
    .tick   (tick)
  );

  assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
  assign clr_vec = wr_stat ? bus_wdata : '0;

  generate
    for (genvar i = 0; i < DW; i++) begin : g_bit
      if (i == BIT_SEC) begin : g_sec
        edge_latch #(.EDGE(1'b0)) u_lat (
          .clk(clk), .rst(rst), .src(tick), .clr(clr_vec[i]), .q(stat[i]));
      end else if (i == BIT_OVF) begin : g_ovf
        edge_latch #(.EDGE(1'b1)) u_lat (
          .clk(clk), .rst(rst), .src(live_s[0]), .clr(clr_vec[i]), .q(stat[i]));
      end else if (i == BIT_LTX) begin : g_ltx
        edge_latch #(.EDGE(1'b1)) u_lat (
          .clk(clk), .rst(rst), .src(live_s[1]), .clr(clr_vec[i]), .q(stat[i]));
      end else if (i == BIT_LRX) begin : g_lrx
        edge_latch #(.EDGE(1'b1)) u_lat (
          .clk(clk), .rst(rst), .src(live_s[2]), .clr(clr_vec[i]), .q(stat[i]));
      end else begin : g_none
        assign stat[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= '0;
      sel <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_IEN)  ien <= bus_wdata & USED_MASK;
      if (bus_addr == ADDR_CTRL) sel <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      irq        <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      irq        <= |(stat & ien);
      if (bus_rd) begin
        case (bus_addr)
          ADDR_STAT: bus_rdata <= stat;
          ADDR_IEN:  bus_rdata <= ien;
          ADDR_CTRL: bus_rdata <= {{(DW-1){1'b0}}, sel};
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst) irq == $past(|(stat & ien))); // R6
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr) == ADDR_STAT) |-> ((bus_rdata & ~USED_MASK) == '0)); // R1
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (rst) ($past(ien) == '0) |-> !irq); // R7
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst) bus_rvalid == $past(bus_rd)); // R1
endmodule

// File: tb/tb_evt_status_reg.sv
module tb_evt_status_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       live_ovf = 1'b0, live_lotc = 1'b0, live_lorc = 1'b0;
  logic       rx_line_clk = 1'b0, tx_in_clk = 1'b0;
  logic       rx_run = 1'b0, tx_run = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb[$];

  evt_status_reg #(.RX_TC(8), .TX_TC(5)) dut (
    .clk(clk), .rst(rst), .live_ovf(live_ovf), .live_lotc(live_lotc), .live_lorc(live_lorc),
    .rx_line_clk(rx_line_clk), .tx_in_clk(tx_in_clk), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq(irq));

  always #10 clk = ~clk;
  always #50 if (rx_run) rx_line_clk = ~rx_line_clk;
  always #70 if (tx_run) tx_in_clk = ~tx_in_clk;

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data %02h, expected none", bus_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (bus_rdata !== e.exp) begin
          errors++;
          $display("FAIL %s: read %02h expected %02h", e.tag, bus_rdata, e.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    exp_t x;
    x.exp = e; x.tag = tag;
    @(negedge clk);
    sb.push_back(x);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq %0b expected %0b", tag, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk_irq(1'b0, "R9 irq after reset");
    rd(8'h09, 8'h00, "R9 status after reset");
    rd(8'h0A, 8'h00, "R9 enables after reset");
    rd(8'h0B, 8'h00, "R9 select after reset");
    // R2 rising edges set bits 1, 6, 7
    live_ovf = 1'b1; idle(5);
    rd(8'h09, 8'h02, "R2 overflow edge");
    live_lotc = 1'b1; idle(5);
    rd(8'h09, 8'h42, "R2 loss of tx clock edge");
    live_lorc = 1'b1; idle(5);
    rd(8'h09, 8'hC2, "R2 loss of rx clock edge");
    // R3 write-0 no effect, write-1 clears
    wr(8'h09, 8'h00);
    rd(8'h09, 8'hC2, "R3 write zero keeps bits");
    wr(8'h09, 8'h02);
    rd(8'h09, 8'hC0, "R3 write one clears bit 1");
    // R4 no re-set while still high
    idle(10);
    rd(8'h09, 8'hC0, "R4 level held, no re-set");
    live_ovf = 1'b0; idle(5);
    live_ovf = 1'b1; idle(5);
    rd(8'h09, 8'hC2, "R2 new rising edge after clear");
    // R6/R7 interrupt gating
    chk_irq(1'b0, "R6 no enables no irq");
    wr(8'h0A, 8'h40);
    chk_irq(1'b1, "R6 enabled bit 6 raises irq");
    wr(8'h0A, 8'h00);
    chk_irq(1'b0, "R7 enable cleared drops irq");
    wr(8'h0A, 8'h40);
    chk_irq(1'b1, "R6 irq back on");
    wr(8'h09, 8'h40);
    chk_irq(1'b0, "R7 status cleared drops irq");
    wr(8'h0A, 8'hFF);
    rd(8'h0A, 8'hC3, "R1 enable unused bits read zero");
    chk_irq(1'b1, "R6 irq from bit 7 or 1");
    wr(8'h09, 8'hFF);
    rd(8'h09, 8'h00, "R1 status all cleared, unused zero");
    chk_irq(1'b0, "R7 all cleared no irq");
    // R8 set wins over simultaneous clear
    live_ovf = 1'b0; idle(5);
    @(negedge clk); live_ovf = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 8'h09; bus_wdata = 8'h02; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    idle(3);
    rd(8'h09, 8'h02, "R8 set wins over clear");
    // R5 one-second tick from rx clock (select 0)
    wr(8'h0A, 8'h01);
    rx_run = 1'b1;
    idle(70);
    rx_run = 1'b0;
    idle(10);
    rd(8'h09, 8'h03, "R5 tick from rx clock");
    chk_irq(1'b1, "R6 tick bit enabled raises irq");
    wr(8'h09, 8'h01);
    idle(80);
    rd(8'h09, 8'h02, "R5 stopped clock, no tick");
    // R5 select tx clock
    wr(8'h0B, 8'h01);
    rd(8'h0B, 8'h01, "R5 select readback");
    tx_run = 1'b1;
    idle(70);
    tx_run = 1'b0;
    idle(10);
    rd(8'h09, 8'h03, "R5 tick from tx clock");
    wr(8'h09, 8'h01);
    rx_run = 1'b1;
    idle(80);
    rx_run = 1'b0;
    idle(10);
    rd(8'h09, 8'h02, "R5 unselected rx clock ignored");
    idle(5);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d reads outstanding, expected 0", sb.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule